// File: doc/BRIEF.md
# Posted Register Write Controller for a One-Second Timekeeper

This block is the host-facing register front end of a timekeeping peripheral whose internal state updates only once per second. It holds a time value, an alarm value, an interrupt-enable mask and a prescaler-enable flag. Host writes to these registers do not land at once. They are parked in a single-entry slot and committed on the next pulse of `sync_tick`, which marks the slow domain's once-per-second sync point. While the slot is occupied, further writes to those registers are thrown away. Host software is expected to poll the pending flag, or to wait for the completion flag, before it issues the next write.

The status register works differently. It collects event pulses from the timekeeping logic, together with the write-complete flag, and the host clears its bits with write-1-to-clear writes that act in the same cycle. The single interrupt line is a level signal. It is high while any status bit is set whose matching enable bit is also set.

Top module: `rtc_host_regs`

## Requirements
- R1: After reset every register reads zero (time, alarm, enable mask, prescaler flag, status), the slot is empty and `irq` is low.
- R2: Register addresses are 0 time (32 bits), 1 alarm (32 bits), 2 interrupt-enable (16 bits), 3 prescaler-enable (bit 0 only, other read bits zero) and 4 status (16 bits). A write to addresses 0 to 3 with the slot empty fills the slot, and status bit 14 (pending) reads 1 from the next cycle.
- R3: The first `sync_tick` seen in a cycle after the write commits the slot. From the following cycle the target register holds the new value, status bit 14 reads 0 and status bit 15 (write complete) reads 1. A tick in the same cycle as the write does not commit it.
- R4: A write to addresses 0 to 3 while the slot is occupied is discarded and has no effect on any register.
- R5: A write to address 4 clears, in the next cycle, every status bit written as 1 and leaves status bit 14 unchanged.
- R6: A pulse on `evt[i]` (i = 0..6) sets status bit i in the next cycle, whatever the enable mask holds.
- R7: `irq` is high exactly when some status bit and the same bit of the enable mask are both 1.
- R8: Reads of addresses 0 to 3 return the last committed value, never the value waiting in the slot.
- R9: When an event pulse and a clear of the same status bit fall in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 3 | Write register select |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register select |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| sync_tick | input | 1 | One-cycle pulse marking the slow-domain sync point |
| evt | input | 7 | One-cycle event pulses, one per status bit 6..0 |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take `sync_tick`, `evt` and `wr_en` to be clean single-cycle pulses that are synchronous to `clk`. They also assume a status clear is judged only in cycles with no event and no commit, because either of those may legitimately set bits again. The stimulus drives every input on the falling edge, holds it for exactly one rising edge and then returns it to zero. Ticks are issued only through explicit cycles, so each commit falls on a cycle the bench chose. Collisions (a write during pending, a tick in the same cycle as a write, an event against a clear) are created on purpose, one at a time.

// File: rtl/rtcw_pkg.sv
package rtcw_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int STAT_W = 16;
    localparam int EVT_W  = 7;

    localparam int BIT_DONE = 15;
    localparam int BIT_PEND = 14;

    typedef enum logic [ADDR_W-1:0] {
        SEL_TIME  = 3'd0,
        SEL_ALARM = 3'd1,
        SEL_IEN   = 3'd2,
        SEL_PSEN  = 3'd3,
        SEL_STAT  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } post_t;

    function automatic logic is_posted(input logic [ADDR_W-1:0] a);
        return (a == SEL_TIME) || (a == SEL_ALARM) ||
               (a == SEL_IEN)  || (a == SEL_PSEN);
    endfunction

endpackage

// File: rtl/rtcw_post_slot.sv
module rtcw_post_slot
    import rtcw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_vld,
    input  post_t req,
    input  logic  tick,
    output logic  busy,
    output logic  apply,
    output post_t entry
);
    logic  vld_q;
    post_t ent_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            ent_q <= '0;
        end else if (vld_q) begin
            if (tick) vld_q <= 1'b0;
        end else if (req_vld) begin
            vld_q <= 1'b1;
            ent_q <= req;
        end
    end

    assign busy  = vld_q;
    assign apply = vld_q && tick;
    assign entry = ent_q;
endmodule

// File: rtl/rtcw_reg_bank.sv
module rtcw_reg_bank
    import rtcw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              apply,
    input  post_t             entry,
    output logic [DATA_W-1:0] time_q,
    output logic [DATA_W-1:0] alarm_q,
    output logic [STAT_W-1:0] ien_q,
    output logic              psen_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            time_q  <= '0;
            alarm_q <= '0;
            ien_q   <= '0;
            psen_q  <= 1'b0;
        end else if (apply) begin
            unique case (entry.sel)
                SEL_TIME:  time_q  <= entry.data;
                SEL_ALARM: alarm_q <= entry.data;
                SEL_IEN:   ien_q   <= entry.data[STAT_W-1:0];
                SEL_PSEN:  psen_q  <= entry.data[0];
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/rtcw_stat_unit.sv
module rtcw_stat_unit
    import rtcw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_vld,
    input  logic [STAT_W-1:0] clr_mask,
    input  logic [EVT_W-1:0]  evt,
    input  logic              done_set,
    input  logic              busy,
    input  logic [STAT_W-1:0] ien,
    output logic [STAT_W-1:0] stat,
    output logic              irq
);
    localparam logic [STAT_W-1:0] KEEP_MASK =
        STAT_W'((1 << EVT_W) - 1) | (STAT_W'(1) << BIT_DONE);

    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] set_v;
    logic [STAT_W-1:0] clr_v;

    always_comb begin
        set_v = '0;
        set_v[EVT_W-1:0] = evt;
        set_v[BIT_DONE]  = done_set;
        clr_v = clr_vld ? clr_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= ((stat_q & ~clr_v) | set_v) & KEEP_MASK;
    end

    always_comb begin
        stat = stat_q;
        stat[BIT_PEND] = busy;
    end

    assign irq = |(stat & ien);
endmodule

// File: rtl/rtc_host_regs.sv
module rtc_host_regs
    import rtcw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sync_tick,
    input  logic [EVT_W-1:0]  evt,
    output logic              irq
);
    logic              post_vld;
    logic              clr_vld;
    post_t             post_req;
    post_t             slot_ent;
    logic              slot_busy;
    logic              slot_apply;
    logic [DATA_W-1:0] time_w;
    logic [DATA_W-1:0] alarm_w;
    logic [STAT_W-1:0] ien_w;
    logic              psen_w;
    logic [STAT_W-1:0] stat_w;

    assign post_vld      = wr_en && is_posted(wr_addr);
    assign clr_vld       = wr_en && (wr_addr == SEL_STAT);
    assign post_req.sel  = reg_sel_e'(wr_addr);
    assign post_req.data = wr_data;

    rtcw_post_slot i_slot (
        .clk     (clk),
        .rst     (rst),
        .req_vld (post_vld),
        .req     (post_req),
        .tick    (sync_tick),
        .busy    (slot_busy),
        .apply   (slot_apply),
        .entry   (slot_ent)
    );

    rtcw_reg_bank i_bank (
        .clk     (clk),
        .rst     (rst),
        .apply   (slot_apply),
        .entry   (slot_ent),
        .time_q  (time_w),
        .alarm_q (alarm_w),
        .ien_q   (ien_w),
        .psen_q  (psen_w)
    );

    rtcw_stat_unit i_stat (
        .clk      (clk),
        .rst      (rst),
        .clr_vld  (clr_vld),
        .clr_mask (wr_data[STAT_W-1:0]),
        .evt      (evt),
        .done_set (slot_apply),
        .busy     (slot_busy),
        .ien      (ien_w),
        .stat     (stat_w),
        .irq      (irq)
    );

    always_comb begin
        unique case (rd_addr)
            SEL_TIME:  rd_data = time_w;
            SEL_ALARM: rd_data = alarm_w;
            SEL_IEN:   rd_data = DATA_W'(ien_w);
            SEL_PSEN:  rd_data = DATA_W'(psen_w);
            SEL_STAT:  rd_data = DATA_W'(stat_w);
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rtc_host_regs_chk.sv
module rtc_host_regs_chk
    import rtcw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              sync_tick,
    input logic [EVT_W-1:0]  evt,
    input logic              busy,
    input logic [STAT_W-1:0] stat,
    input logic [DATA_W-1:0] time_q,
    input logic [DATA_W-1:0] alarm_q,
    input logic [STAT_W-1:0] ien_q,
    input logic              psen_q
);
    p_post_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr < 3'd4) && !busy) |=> busy);

    p_apply_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && sync_tick) |=> (!busy && stat[BIT_DONE]));

    p_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && !sync_tick) |=> ($stable(time_q) && $stable(alarm_q) &&
                                  $stable(ien_q) && $stable(psen_q)));

    p_pend_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == 3'd4) && !sync_tick) |=> (stat[BIT_PEND] == $past(busy)));

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == 3'd4) && (evt == '0) && !(busy && sync_tick))
        |=> ((stat[EVT_W-1:0] & $past(wr_data[EVT_W-1:0])) == '0));

    p_evt_r6: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((stat[EVT_W-1:0] & $past(evt)) == $past(evt)));
endmodule

bind rtc_host_regs rtc_host_regs_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sync_tick (sync_tick),
    .evt       (evt),
    .busy      (slot_busy),
    .stat      (stat_w),
    .time_q    (time_w),
    .alarm_q   (alarm_w),
    .ien_q     (ien_w),
    .psen_q    (psen_w)
);

// File: tb/test_rtc_host_regs.sv
module test_rtc_host_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic [2:0]  rd_addr;
    logic [31:0] rd_data;
    logic        sync_tick;
    logic [6:0]  evt;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [2:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  smp;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_host_regs i_rtc_host_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sync_tick(sync_tick), .evt(evt), .irq(irq)
    );

    // monitor: pops one expected item per sample event and compares
    always @(smp) begin
        item_t it;
        logic [31:0] got;
        it = sb_q.pop_front();
        got = it.is_irq ? {31'd0, irq} : rd_data;
        total++;
        if (got !== it.exp) begin
            bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, got, it.exp);
        end
    end

    task automatic step(input bit w, input logic [2:0] a, input logic [31:0] d,
                        input bit t, input logic [6:0] e);
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_data = d; sync_tick = t; evt = e;
        @(posedge clk);
        #1;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; sync_tick = 1'b0; evt = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        step(1'b1, a, d, 1'b0, '0);
    endtask

    task automatic tick();
        step(1'b0, 3'd0, '0, 1'b1, '0);
    endtask

    task automatic chk(input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        rd_addr = a;
        it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        #1;
        ->smp;
        #1;
    endtask

    task automatic chk_irq(input bit e, input string tag);
        item_t it;
        @(negedge clk);
        it.is_irq = 1'b1; it.addr = '0; it.exp = {31'd0, e}; it.tag = tag;
        sb_q.push_back(it);
        #1;
        ->smp;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        sync_tick = 0; evt = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        for (int a = 0; a < 5; a++) chk(3'(a), 32'h0, "R1 reset value");
        chk_irq(1'b0, "R1 irq after reset");

        wr(3'd0, 32'h1234_5678);
        chk(3'd4, 32'h0000_4000, "R2 pending set");
        chk(3'd0, 32'h0, "R8 slot value not visible");

        wr(3'd0, 32'hDEAD_BEEF);
        wr(3'd2, 32'h0000_FFFF);
        tick();
        chk(3'd0, 32'h1234_5678, "R3 R4 first write applied, later dropped");
        chk(3'd2, 32'h0, "R4 enable write dropped");
        chk(3'd4, 32'h0000_8000, "R3 complete set, pending clear");
        chk_irq(1'b0, "R7 complete not enabled");

        wr(3'd4, 32'h0000_8000);
        chk(3'd4, 32'h0, "R5 complete cleared");

        wr(3'd1, 32'h5);
        wr(3'd4, 32'hFFFF_FFFF);
        chk(3'd4, 32'h0000_4000, "R5 pending not cleared by status write");
        chk(3'd1, 32'h0, "R8 alarm still old");
        tick();
        chk(3'd1, 32'h5, "R3 alarm applied");
        wr(3'd4, 32'hFFFF);

        step(1'b1, 3'd1, 32'h9, 1'b1, '0);
        chk(3'd4, 32'h0000_4000, "R3 same-cycle tick does not commit");
        chk(3'd1, 32'h5, "R3 alarm unchanged before next tick");
        tick();
        chk(3'd1, 32'h9, "R3 alarm applied on next tick");
        wr(3'd4, 32'hFFFF);

        step(1'b0, 3'd0, '0, 1'b0, 7'b000_0101);
        chk(3'd4, 32'h0000_0005, "R6 events set without enable");
        chk_irq(1'b0, "R7 no enabled bit");

        wr(3'd2, 32'h0000_0004);
        tick();
        chk(3'd2, 32'h4, "R2 enable register");
        chk(3'd4, 32'h0000_8005, "R6 status after commit");
        chk_irq(1'b1, "R7 enabled second event");
        wr(3'd4, 32'h0000_0004);
        chk(3'd4, 32'h0000_8001, "R5 single bit clear");
        chk_irq(1'b0, "R7 drops after clear");
        wr(3'd4, 32'hFFFF);

        step(1'b1, 3'd4, 32'h0000_0008, 1'b0, 7'b000_1000);
        chk(3'd4, 32'h0000_0008, "R9 event wins over clear");
        wr(3'd4, 32'hFFFF);

        wr(3'd3, 32'h0000_00FF);
        tick();
        chk(3'd3, 32'h1, "R2 prescaler flag one bit");
        wr(3'd4, 32'hFFFF);
        chk(3'd4, 32'h0, "R5 all cleared");

        wr(3'd2, 32'h0000_8000);
        tick();
        chk_irq(1'b1, "R7 write complete enabled");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule